// File: doc/BRIEF.md
# Paged memory address translator

This block maps the 16-bit local address space of a CPU onto a wider global space. It holds two mapping registers. The direct-page register supplies the high byte of the local address for direct-mode accesses. The program-page index picks which 16KB Flash page shows through the paged window.

The translation path is purely combinational. In direct mode the local address is formed from the direct-page byte and the 8-bit operand. Otherwise the incoming local address is used as is. If the resulting local address falls in the window from 0x8000 to 0xBFFF, its top two bits are replaced by the 4-bit page index. This gives an 18-bit Flash address that can reach 256KB, and a window flag is raised. Any other address is zero-extended and the flag stays low.

Software reaches both registers through a simple write/read port. A separate load port lets the CPU set the page index while it executes call and return-from-call instructions.

Top module: `page_xlate`

## Requirements
- R1: After reset the direct-page register reads 0x00 (register address 0x31) and the page index reads 0x0E (register address 0x30).
- R2: With `dir_mode_i` high, the local address is {direct-page byte, `dir_ofs_i`}, and `lcl_addr_i` is ignored.
- R3: Only the first write to address 0x31 after reset updates the direct-page register. Later writes leave it unchanged until the next reset.
- R4: The page index at address 0x30 takes `reg_wdata_i[3:0]` on any write at any time. Reads return {4'b0000, index}.
- R5: For a local address from 0x8000 to 0xBFFF, `glb_addr_o` = {index, local[13:0]} and `flash_win_o` = 1, in the same cycle.
- R6: For any other local address, `glb_addr_o` = {2'b00, local} and `flash_win_o` = 0.
- R7: `call_ld_i` high loads `call_page_i` into the page index at the next clock edge.
- R8: When `call_ld_i` and a register write to 0x30 occur in the same cycle, the call/return value is loaded.
- R9: A read at any register address other than 0x30 or 0x31 returns 0x00.
- R10: A direct-mode local address that lands in the window is translated by the page index as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address for writes and reads |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| call_ld_i | input | 1 | Page load from a call/return instruction |
| call_page_i | input | 4 | Page value for the call/return load |
| lcl_addr_i | input | 16 | Local CPU address |
| dir_mode_i | input | 1 | Access uses direct addressing |
| dir_ofs_i | input | 8 | Direct-mode operand byte |
| glb_addr_o | output | 18 | Translated global address |
| flash_win_o | output | 1 | Address lies in the paged Flash window |

## Verification
The bench probes both edges of the window: 0x7FFF, 0x8000, 0xBFFF and 0xC000. A design with an off-by-one window decode would flag the wrong neighbour or fail to substitute the page there. It writes the direct-page register twice, then resets and writes it again. A missing lock would show the second value, and a lock that survives reset would block the fresh write. It also drives a call/return load and a register write to the index in the same cycle. A design with the priority reversed would read back the written value instead of the loaded one.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int unsigned LA_W    = 16;
  localparam int unsigned DW      = 8;
  localparam int unsigned PIX_W   = 4;
  localparam int unsigned RA_W    = 8;
  localparam int unsigned WIN_LSB = 14;
  localparam int unsigned GA_W    = PIX_W + WIN_LSB;

  localparam logic [RA_W-1:0]  PIX_ADDR = 8'h30;
  localparam logic [RA_W-1:0]  DP_ADDR  = 8'h31;
  localparam logic [PIX_W-1:0] PIX_RST  = 4'hE;
  localparam logic [1:0]       WIN_TAG  = 2'b10;
endpackage

// File: rtl/pgx_dp_reg.sv
module pgx_dp_reg #(
  parameter int unsigned DW = pgx_pkg::DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] dp_o,
  output logic          locked_o
);
  logic [DW-1:0] dp_q;
  logic          lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dp_q   <= '0;
      lock_q <= 1'b0;
    end else if (wr_i && !lock_q) begin
      dp_q   <= wdata_i;
      lock_q <= 1'b1;
    end
  end

  assign dp_o     = dp_q;
  assign locked_o = lock_q;
endmodule

// File: rtl/pgx_pix_reg.sv
module pgx_pix_reg #(
  parameter int unsigned          PIX_W = pgx_pkg::PIX_W,
  parameter logic [PIX_W-1:0]     RST_V = pgx_pkg::PIX_RST
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [PIX_W-1:0] wdata_i,
  input  logic             ld_i,
  input  logic [PIX_W-1:0] ld_data_i,
  output logic [PIX_W-1:0] pix_o
);
  logic [PIX_W-1:0] pix_q;

  // call/return load has priority over register write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pix_q <= RST_V;
    else if (ld_i)  pix_q <= ld_data_i;
    else if (wr_i)  pix_q <= wdata_i;
  end

  assign pix_o = pix_q;
endmodule

// File: rtl/pgx_xlate.sv
module pgx_xlate #(
  parameter int unsigned LA_W    = pgx_pkg::LA_W,
  parameter int unsigned DW      = pgx_pkg::DW,
  parameter int unsigned PIX_W   = pgx_pkg::PIX_W,
  parameter int unsigned WIN_LSB = pgx_pkg::WIN_LSB,
  localparam int unsigned GA_W   = PIX_W + WIN_LSB,
  localparam int unsigned OFS_W  = LA_W - DW
) (
  input  logic [LA_W-1:0]  lcl_addr_i,
  input  logic             dir_mode_i,
  input  logic [OFS_W-1:0] dir_ofs_i,
  input  logic [DW-1:0]    dp_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic [GA_W-1:0]  glb_addr_o,
  output logic             win_o
);
  logic [LA_W-1:0] eff;

  always_comb begin
    eff   = dir_mode_i ? {dp_i, dir_ofs_i} : lcl_addr_i;
    win_o = (eff[LA_W-1 -: 2] == pgx_pkg::WIN_TAG);
    if (win_o) glb_addr_o = {pix_i, eff[WIN_LSB-1:0]};
    else       glb_addr_o = GA_W'(eff);
  end
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import pgx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              call_ld_i,
  input  logic [PIX_W-1:0]  call_page_i,
  input  logic [LA_W-1:0]   lcl_addr_i,
  input  logic              dir_mode_i,
  input  logic [LA_W-DW-1:0] dir_ofs_i,
  output logic [GA_W-1:0]   glb_addr_o,
  output logic              flash_win_o
);
  logic [DW-1:0]    dp_w;
  logic             dp_lock_w;
  logic [PIX_W-1:0] pix_w;
  logic             dp_wr, pix_wr;

  assign dp_wr  = reg_wr_i && (reg_addr_i == DP_ADDR);
  assign pix_wr = reg_wr_i && (reg_addr_i == PIX_ADDR);

  pgx_dp_reg #(.DW(DW)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (dp_wr),
    .wdata_i  (reg_wdata_i),
    .dp_o     (dp_w),
    .locked_o (dp_lock_w)
  );

  pgx_pix_reg #(.PIX_W(PIX_W), .RST_V(PIX_RST)) u_pix (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (pix_wr),
    .wdata_i   (reg_wdata_i[PIX_W-1:0]),
    .ld_i      (call_ld_i),
    .ld_data_i (call_page_i),
    .pix_o     (pix_w)
  );

  pgx_xlate #(.LA_W(LA_W), .DW(DW), .PIX_W(PIX_W), .WIN_LSB(WIN_LSB)) u_xl (
    .lcl_addr_i (lcl_addr_i),
    .dir_mode_i (dir_mode_i),
    .dir_ofs_i  (dir_ofs_i),
    .dp_i       (dp_w),
    .pix_i      (pix_w),
    .glb_addr_o (glb_addr_o),
    .win_o      (flash_win_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      PIX_ADDR: reg_rdata_o = DW'(pix_w);
      DP_ADDR:  reg_rdata_o = dp_w;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk
  import pgx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [RA_W-1:0]   reg_addr_i,
  input logic [DW-1:0]     reg_wdata_i,
  input logic [DW-1:0]     reg_rdata_o,
  input logic              call_ld_i,
  input logic [PIX_W-1:0]  call_page_i,
  input logic [LA_W-1:0]   lcl_addr_i,
  input logic              dir_mode_i,
  input logic [LA_W-DW-1:0] dir_ofs_i,
  input logic [GA_W-1:0]   glb_addr_o,
  input logic              flash_win_o,
  input logic [DW-1:0]     dp_q,
  input logic              dp_lock_q,
  input logic [PIX_W-1:0]  pix_q
);
  assert_dp_write_once_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dp_lock_q |=> $stable(dp_q));

  assert_first_dp_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dp_lock_q && reg_wr_i && reg_addr_i == DP_ADDR) |=> (dp_q == $past(reg_wdata_i)));

  assert_call_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_ld_i |=> (pix_q == $past(call_page_i)));

  assert_pix_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == PIX_ADDR && !call_ld_i) |=> (pix_q == $past(reg_wdata_i[PIX_W-1:0])));

  assert_pix_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == PIX_ADDR) |-> (reg_rdata_o[DW-1:PIX_W] == '0));

  assert_window_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_mode_i |-> (flash_win_o == (lcl_addr_i >= 16'h8000 && lcl_addr_i <= 16'hBFFF)));

  assert_window_page_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_win_o |-> (glb_addr_o[GA_W-1 -: PIX_W] == pix_q));

  assert_outside_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_win_o |-> (glb_addr_o[GA_W-1:LA_W] == '0));

  assert_direct_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_mode_i |-> (glb_addr_o[LA_W-DW-1:0] == dir_ofs_i));
endmodule

bind page_xlate page_xlate_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .call_ld_i   (call_ld_i),
  .call_page_i (call_page_i),
  .lcl_addr_i  (lcl_addr_i),
  .dir_mode_i  (dir_mode_i),
  .dir_ofs_i   (dir_ofs_i),
  .glb_addr_o  (glb_addr_o),
  .flash_win_o (flash_win_o),
  .dp_q        (dp_w),
  .dp_lock_q   (dp_lock_w),
  .pix_q       (pix_w)
);

// File: tb/tb_page_xlate.sv
`timescale 1ns/1ps
module tb_page_xlate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        call_ld_i = 1'b0;
  logic [3:0]  call_page_i = '0;
  logic [15:0] lcl_addr_i = '0;
  logic        dir_mode_i = 1'b0;
  logic [7:0]  dir_ofs_i = '0;
  logic [17:0] glb_addr_o;
  logic        flash_win_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference state
  int m_dp, m_pix;
  bit m_lock;

  always #4 clk_i = ~clk_i;

  page_xlate dut (.*);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_dp = 0; m_pix = 14; m_lock = 0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    model_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // one cycle: drive at negedge, compare before posedge, update model after it
  task automatic cyc(string req, bit wr, int addr, int wd, bit ld, int ldp,
                     int la, bit dm, int ofs);
    int eff, exp_ga, exp_rd;
    bit exp_win;
    reg_wr_i = wr; reg_addr_i = addr[7:0]; reg_wdata_i = wd[7:0];
    call_ld_i = ld; call_page_i = ldp[3:0];
    lcl_addr_i = la[15:0]; dir_mode_i = dm; dir_ofs_i = ofs[7:0];
    #2;
    eff = dm ? (m_dp * 256 + ofs) : la;
    exp_win = (eff >= 'h8000) && (eff <= 'hBFFF);
    exp_ga  = exp_win ? (m_pix * 16384 + (eff - 'h8000)) : eff;
    exp_rd  = (addr == 'h30) ? m_pix : (addr == 'h31) ? m_dp : 0;
    chk(req, "glb_addr", int'(glb_addr_o), exp_ga);
    chk(req, "flash_win", int'(flash_win_o), int'(exp_win));
    chk(req, "rdata", int'(reg_rdata_o), exp_rd);
    @(posedge clk_i);
    #1;
    if (ld) m_pix = ldp;
    else if (wr && addr == 'h30) m_pix = wd % 16;
    if (wr && addr == 'h31 && !m_lock) begin
      m_dp = wd; m_lock = 1;
    end
    @(negedge clk_i);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();
    // R1 reset values
    cyc("R1", 0, 'h30, 0, 0, 0, 'h0000, 0, 0);
    cyc("R1", 0, 'h31, 0, 0, 0, 'h8000, 0, 0);
    // R5/R6 window edges
    cyc("R6", 0, 'h30, 0, 0, 0, 'h7FFF, 0, 0);
    cyc("R5", 0, 'h30, 0, 0, 0, 'h8000, 0, 0);
    cyc("R5", 0, 'h30, 0, 0, 0, 'hBFFF, 0, 0);
    cyc("R6", 0, 'h30, 0, 0, 0, 'hC000, 0, 0);
    cyc("R6", 0, 'h30, 0, 0, 0, 'hFFFF, 0, 0);
    // R4 index write, upper bits dropped
    cyc("R4", 1, 'h30, 'h35, 0, 0, 'h1234, 0, 0);
    cyc("R4", 0, 'h30, 0, 0, 0, 'h9234, 0, 0);
    // R7 call/return load
    cyc("R7", 0, 'h30, 0, 1, 3, 'hA000, 0, 0);
    cyc("R7", 0, 'h30, 0, 0, 0, 'hA001, 0, 0);
    // R8 both in the same cycle
    cyc("R8", 1, 'h30, 'h0A, 1, 9, 'h4000, 0, 0);
    cyc("R8", 0, 'h30, 0, 0, 0, 'hB123, 0, 0);
    // R3 first write takes, second ignored
    cyc("R3", 1, 'h31, 'h80, 0, 0, 'h0000, 0, 0);
    cyc("R3", 1, 'h31, 'h12, 0, 0, 'h0000, 0, 0);
    cyc("R3", 0, 'h31, 0, 0, 0, 'h0000, 0, 0);
    // R10 direct access landing in the window
    cyc("R10", 0, 'h30, 0, 0, 0, 'h0000, 1, 'h00);
    cyc("R10", 0, 'h30, 0, 0, 0, 'hFFFF, 1, 'h55);
    // R9 unmapped reads
    cyc("R9", 0, 'h44, 0, 0, 0, 'h2000, 0, 0);
    cyc("R9", 0, 'h2F, 0, 0, 0, 'h2000, 0, 0);
    // R3 lock cleared by reset; R2 direct mode outside the window
    do_reset();
    cyc("R1", 0, 'h31, 0, 0, 0, 'h0000, 0, 0);
    cyc("R3", 1, 'h31, 'h12, 0, 0, 'h0000, 0, 0);
    cyc("R2", 0, 'h31, 0, 0, 0, 'hBEEF, 1, 'h34);
    cyc("R2", 0, 'h31, 0, 0, 0, 'h8000, 1, 'hFF);
    // sweep pages and addresses
    for (int p = 0; p < 16; p++) begin
      cyc("R7", 0, 'h30, 0, 1, p, 'h0100 * p, 0, 0);
      for (int a = 0; a < 8; a++)
        cyc(((a * 'h2345 + p) % 65536) >= 'h8000 && ((a * 'h2345 + p) % 65536) < 'hC000 ? "R5" : "R6",
            0, 'h30, 0, 0, 0, (a * 'h2345 + p) % 65536, 0, 0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule